// File: doc/BRIEF.md
# Four-Channel Output-Compare Timer

This block is the core of a timer peripheral. A single up counter, paced by a programmable clock divider, runs from zero to a programmable wrap limit and then restarts at zero. Each restart produces a one-cycle update pulse. The counter is shared by four channels. Each channel holds its own compare value, and each reacts when the counter reaches that value. On such a match the channel changes a reference level as its mode field selects. It also latches a status flag and can raise an interrupt and a DMA request.

A channel's pin level follows from its reference level, a polarity bit and an output-enable bit. Compare values can be written in two ways. They can take effect at once, or they can be staged in a holding register that is copied into the live compare value only at the next wrap. A simple synchronous port configures the block: a write strobe with address and data, and a read address with a registered read result. Software that adds a fixed step to a compare value after each match gets a square wave on the pin. Its half-period is the step times the divider ratio.

Top module: `oc_timer`

## Requirements
- R1: After a synchronous reset every register reads zero, the counter is stopped, all flags are clear and every pin is at its inactive level (low).
- R2: With bit 0 of the control register (address 0) set, the counter (readable at address 6) advances by one every PSC+1 clocks, where PSC is held at address 1. With that bit clear, the counter holds.
- R3: On the counter tick where the count is at or above the wrap limit (address 2), the counter returns to 0 and `upd_o` pulses high for exactly one cycle.
- R4: Each channel's configuration byte sits at bits 8c+7..8c of address 3. Bits 2:0 of that byte select the mode: 000 keeps the reference level, 001 sets it active, 010 sets it inactive, 011 inverts it on each match, and 1xx keeps it.
- R5: A match is detected only on a counter tick whose new count equals the channel's live compare value. It is not detected again while the divider holds that count.
- R6: Every match sets the channel's flag (bit c at address 4) in any mode. Writing 1 to bit c at address 5 clears the flag, and a set in the same cycle wins over the clear.
- R7: `irq_o` is high whenever some channel has both its flag set and bit 6 (interrupt enable) of its configuration byte set.
- R8: `dma_o[c]` pulses for one cycle after each match of channel c while bit 7 (DMA enable) of its configuration byte is set.
- R9: The compare value for channel c is written at address 8+c and reads back its live value. With bit 3 (staging) clear, the write is live at once. With bit 3 set, the write is held and becomes live at the next update event.
- R10: The update event changes no reference level and no pin.
- R11: With bit 5 (output enable) set, the pin equals the reference level XOR bit 4 (polarity).
- R12: With bit 5 clear, the pin is held at its inactive level, which equals the polarity bit.
- R13: If the compare value is raised by a step of N after each match in invert mode with PSC 0, the pin toggles exactly every N clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Registered read data, one cycle after rd_addr |
| pin_o | output | 4 | Channel pin levels |
| irq_o | output | 1 | Combined interrupt request |
| dma_o | output | 4 | Per-channel DMA request pulses |
| upd_o | output | 1 | Update event pulse on counter wrap |

## Verification
On every cycle the assertions check several properties. The counter moves by at most one step or returns to zero, and it holds while stopped. A reference level moves only on a match, and never in the keep modes. Each match leaves its flag set, and a DMA pulse appears only with its enable set. Other behaviour can be shown only by the bench's scenarios. These are the exact divider ratio, the staged compare value taking effect at the wrap, set-over-clear on the flags, the polarity and output-enable mapping, and the toggle period produced by stepping the compare value. The bench runs a cycle model alongside the design, using both random and directed register traffic.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_PSC  = 4'd1;
  localparam logic [ADDR_W-1:0] A_WRAP = 4'd2;
  localparam logic [ADDR_W-1:0] A_CFG  = 4'd3;
  localparam logic [ADDR_W-1:0] A_FLAG = 4'd4;
  localparam logic [ADDR_W-1:0] A_FCLR = 4'd5;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd6;
  localparam int                A_CMP0 = 8;

  typedef enum logic [2:0] {
    OCM_KEEP     = 3'b000,
    OCM_SET      = 3'b001,
    OCM_CLEAR    = 3'b010,
    OCM_INVERT   = 3'b011
  } ocm_e;

  typedef struct packed {
    logic       dma_en;
    logic       irq_en;
    logic       out_en;
    logic       pol;
    logic       stage_en;
    logic [2:0] mode;
  } ch_cfg_t;
endpackage

// File: rtl/oc_timebase.sv
module oc_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] wrap,
  output logic             tick,
  output logic             upd_ev,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt
);
  logic [PSC_W-1:0] div_q;

  always_comb begin
    tick    = run && (div_q >= psc);
    upd_ev  = tick && (cnt >= wrap);
    cnt_nxt = cnt;
    if (tick) cnt_nxt = upd_ev ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt   <= '0;
    end else begin
      div_q <= (!run || tick) ? '0 : div_q + 1'b1;
      cnt   <= cnt_nxt;
    end
  end

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt)); // R2
  AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> (cnt == '0) || (cnt == $past(cnt) + 1'b1)); // R3
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             upd_ev,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  ch_cfg_t          cfg,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cmp_live,
  output logic             flag_q,
  output logic             dma_q,
  output logic             pin
);
  logic [CNT_W-1:0] cmp_hold;
  logic             ref_q;
  logic             ref_nxt;
  logic             hit;

  assign hit = tick && (cnt_nxt == cmp_live);

  always_comb begin
    ref_nxt = ref_q;
    if (hit) begin
      case (cfg.mode)
        OCM_SET:    ref_nxt = 1'b1;
        OCM_CLEAR:  ref_nxt = 1'b0;
        OCM_INVERT: ref_nxt = ~ref_q;
        default:    ref_nxt = ref_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_live <= '0;
      cmp_hold <= '0;
      ref_q    <= 1'b0;
      flag_q   <= 1'b0;
      dma_q    <= 1'b0;
    end else begin
      ref_q  <= ref_nxt;
      flag_q <= hit | (flag_q & ~flag_clr);
      dma_q  <= hit & cfg.dma_en;
      if (cmp_we) cmp_hold <= cmp_wdata;
      if (cmp_we && !cfg.stage_en) cmp_live <= cmp_wdata;
      else if (upd_ev && cfg.stage_en) cmp_live <= cmp_hold;
    end
  end

  assign pin = cfg.out_en ? (ref_q ^ cfg.pol) : cfg.pol;

  AST_KEEP_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode[2] || cfg.mode == OCM_KEEP) |=> $stable(ref_q)); // R4
  AST_REF_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(ref_q)); // R10
  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q); // R6
  AST_DMA_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    dma_q |-> $past(cfg.dma_en)); // R8
endmodule

// File: rtl/oc_timer.sv
module oc_timer
  import oc_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] pin_o,
  output logic              irq_o,
  output logic [NUM_CH-1:0] dma_o,
  output logic              upd_o
);
  localparam int CFG_W = 8 * NUM_CH;

  logic             run_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] wrap_q;
  logic [CFG_W-1:0] cfg_q;
  logic             tick, upd_ev;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic [CNT_W-1:0] cmp_live [NUM_CH];
  logic [NUM_CH-1:0] flag_vec, ie_vec;
  logic [DATA_W-1:0] rd_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      psc_q  <= '0;
      wrap_q <= '0;
      cfg_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  run_q  <= wr_data[0];
        A_PSC:   psc_q  <= wr_data[PSC_W-1:0];
        A_WRAP:  wrap_q <= wr_data[CNT_W-1:0];
        A_CFG:   cfg_q  <= wr_data[CFG_W-1:0];
        default: ;
      endcase
    end
  end

  oc_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_base (
    .clk(clk), .rst(rst), .run(run_q), .psc(psc_q), .wrap(wrap_q),
    .tick(tick), .upd_ev(upd_ev), .cnt(cnt), .cnt_nxt(cnt_nxt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ch_cfg_t cc;
    assign cc        = ch_cfg_t'(cfg_q[8*c +: 8]);
    assign ie_vec[c] = cc.irq_en;

    oc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .upd_ev(upd_ev), .cnt_nxt(cnt_nxt),
      .cfg(cc),
      .cmp_we(wr_en && (wr_addr == ADDR_W'(A_CMP0 + c))),
      .cmp_wdata(wr_data[CNT_W-1:0]),
      .flag_clr(wr_en && (wr_addr == A_FCLR) && wr_data[c]),
      .cmp_live(cmp_live[c]), .flag_q(flag_vec[c]), .dma_q(dma_o[c]),
      .pin(pin_o[c])
    );
  end

  assign irq_o = |(flag_vec & ie_vec);

  always_comb begin
    rd_nxt = '0;
    case (rd_addr)
      A_CTRL:  rd_nxt[0]          = run_q;
      A_PSC:   rd_nxt[PSC_W-1:0]  = psc_q;
      A_WRAP:  rd_nxt[CNT_W-1:0]  = wrap_q;
      A_CFG:   rd_nxt[CFG_W-1:0]  = cfg_q;
      A_FLAG:  rd_nxt[NUM_CH-1:0] = flag_vec;
      A_CNT:   rd_nxt[CNT_W-1:0]  = cnt;
      default: begin
        for (int c = 0; c < NUM_CH; c++)
          if (rd_addr == ADDR_W'(A_CMP0 + c)) rd_nxt[CNT_W-1:0] = cmp_live[c];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      upd_o   <= 1'b0;
    end else begin
      rd_data <= rd_nxt;
      upd_o   <= upd_ev;
    end
  end

  AST_UPD_LANDS_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> (cnt == '0)); // R3
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flag_vec != '0)); // R7
endmodule

// File: tb/oc_timer_bench.sv
module oc_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  pin_o, dma_o;
  logic        irq_o, upd_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  bit mon_on = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  oc_timer u_oc_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_o(pin_o), .irq_o(irq_o),
    .dma_o(dma_o), .upd_o(upd_o)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] cfgb(logic [2:0] mode, logic stage, logic pol,
                                      logic oe, logic ie, logic de);
    return {de, ie, oe, pol, stage, mode};
  endfunction

  // Cycle model built from the requirements
  logic        m_run;
  logic [15:0] m_psc, m_div, m_wrap, m_cnt;
  logic [31:0] m_cfg, m_rd;
  logic [15:0] m_live [4];
  logic [15:0] m_hold [4];
  logic [3:0]  m_ref, m_flag, m_dma;
  logic        m_upd;

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a)
      4'd0: return {31'd0, m_run};
      4'd1: return {16'd0, m_psc};
      4'd2: return {16'd0, m_wrap};
      4'd3: return m_cfg;
      4'd4: return {28'd0, m_flag};
      4'd6: return {16'd0, m_cnt};
      4'd8, 4'd9, 4'd10, 4'd11: return {16'd0, m_live[a-8]};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic tk, up;
    logic [15:0] nx;
    logic [7:0] cf;
    logic mt;
    if (rst) begin
      m_run <= 0; m_psc <= 0; m_div <= 0; m_wrap <= 0; m_cnt <= 0; m_cfg <= 0;
      m_ref <= 0; m_flag <= 0; m_dma <= 0; m_upd <= 0; m_rd <= 0;
      for (int c = 0; c < 4; c++) begin m_live[c] <= 0; m_hold[c] <= 0; end
    end else begin
      tk = m_run && (m_div >= m_psc);
      up = tk && (m_cnt >= m_wrap);
      nx = !tk ? m_cnt : (up ? 16'd0 : m_cnt + 16'd1);
      m_rd  <= m_read(rd_addr);
      m_upd <= up;
      m_cnt <= nx;
      m_div <= (!m_run || tk) ? 16'd0 : m_div + 16'd1;
      for (int c = 0; c < 4; c++) begin
        cf = m_cfg[8*c +: 8];
        mt = tk && (nx == m_live[c]);
        if (mt) begin
          if (cf[2:0] == 3'b001) m_ref[c] <= 1'b1;
          else if (cf[2:0] == 3'b010) m_ref[c] <= 1'b0;
          else if (cf[2:0] == 3'b011) m_ref[c] <= ~m_ref[c];
        end
        m_dma[c]  <= mt & cf[7];
        m_flag[c] <= mt | (m_flag[c] & ~(wr_en && wr_addr == 4'd5 && wr_data[c]));
        if (wr_en && wr_addr == 4'(8 + c)) begin
          m_hold[c] <= wr_data[15:0];
          if (!cf[3]) m_live[c] <= wr_data[15:0];
        end
        if (!(wr_en && wr_addr == 4'(8 + c) && !cf[3]) && up && cf[3])
          m_live[c] <= m_hold[c];
      end
      if (wr_en) begin
        case (wr_addr)
          4'd0: m_run  <= wr_data[0];
          4'd1: m_psc  <= wr_data[15:0];
          4'd2: m_wrap <= wr_data[15:0];
          4'd3: m_cfg  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (mon_on && !done) begin
      logic [3:0] ep;
      logic [7:0] cf;
      for (int c = 0; c < 4; c++) begin
        cf = m_cfg[8*c +: 8];
        ep[c] = cf[5] ? (m_ref[c] ^ cf[4]) : cf[4];
      end
      chk("R4", "pins vs model", {28'd0, pin_o}, {28'd0, ep});
      chk("R7", "irq vs model", {31'd0, irq_o},
          {31'd0, |(m_flag & {m_cfg[30], m_cfg[22], m_cfg[14], m_cfg[6]})});
      chk("R8", "dma vs model", {28'd0, dma_o}, {28'd0, m_dma});
      chk("R3", "upd vs model", {31'd0, upd_o}, {31'd0, m_upd});
      chk("R6", "read data vs model", rd_data, m_rd);
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2, cfgw, base;
    int t [6];
    int pulses;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    mon_on = 1;

    // R1 reset state
    rd(4'd6, v); chk("R1", "counter after reset", v, 0);
    rd(4'd4, v); chk("R1", "flags after reset", v, 0);
    chk("R1", "pins after reset", {28'd0, pin_o}, 0);

    // R11 / R12 with counter stopped
    cfgw = 0;
    cfgw[23:16] = cfgb(3'b000, 0, 1, 1, 0, 0);
    cfgw[31:24] = cfgb(3'b001, 0, 0, 0, 0, 1);
    wr(4'd3, cfgw);
    chk("R11", "pin2 inverted polarity", {31'd0, pin_o[2]}, 1);
    chk("R12", "pin3 disabled", {31'd0, pin_o[3]}, 0);

    // R2 divider ratio, R5 single detection, R12 gating
    wr(4'd11, 2);
    wr(4'd1, 2);
    wr(4'd2, 100);
    wr(4'd0, 1);
    pulses = 0;
    rd_addr = 4'd6;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (dma_o[3]) pulses++;
      if (i == 15) v = rd_data;
      if (i == 24) v2 = rd_data;
    end
    chk("R2", "ticks over 9 clocks at PSC 2", v2 - v, 3);
    chk("R5", "one detection per held count", pulses, 1);
    chk("R12", "pin3 held with ref active", {31'd0, pin_o[3]}, 0);
    cfgw[31:24] = cfgb(3'b001, 0, 0, 1, 0, 0);
    wr(4'd3, cfgw);
    chk("R11", "pin3 shows active ref", {31'd0, pin_o[3]}, 1);

    // R13 stepped compare toggle
    wr(4'd2, 32'hFFFF);
    wr(4'd1, 0);
    cfgw[7:0] = cfgb(3'b011, 0, 0, 1, 1, 1);
    wr(4'd3, cfgw);
    rd(4'd6, v);
    base = v + 20;
    wr(4'd8, base);
    for (int k = 0; k < 6; k++) begin
      do @(negedge clk); while (!dma_o[0]);
      t[k] = cyc;
      chk("R13", "pin0 alternates", {31'd0, pin_o[0]}, (k % 2 == 0) ? 1 : 0);
      base = base + 7;
      wr_en = 1'b1; wr_addr = 4'd8; wr_data = base;
      @(negedge clk);
      wr_en = 1'b0;
    end
    for (int k = 1; k < 6; k++)
      chk("R13", "toggle interval", t[k] - t[k-1], 7);

    // R7 / R6 flag clear
    chk("R7", "irq with flag and enable", {31'd0, irq_o}, 1);
    wr(4'd5, 1);
    rd(4'd4, v);
    chk("R6", "flag0 cleared by write-one", v[0], 0);
    chk("R7", "irq drops after clear", {31'd0, irq_o}, 0);

    // R9 staged compare
    wr(4'd2, 20);
    cfgw[15:8] = cfgb(3'b000, 1, 0, 0, 0, 0);
    wr(4'd3, cfgw);
    rd(4'd9, v);
    wr(4'd9, 5);
    rd(4'd9, v2);
    chk("R9", "staged write not yet live", v2, v);
    rd_addr = 4'd9;
    do @(negedge clk); while (!upd_o);
    @(negedge clk);
    chk("R9", "staged value live after update", rd_data, 5);

    // R10 update leaves pins alone
    cfgw[23:16] = cfgb(3'b011, 0, 1, 1, 0, 0);
    wr(4'd10, 50);
    wr(4'd3, cfgw);
    wr(4'd2, 4);
    v = {28'd0, pin_o};
    for (int k = 0; k < 3; k++) begin
      do @(negedge clk); while (!upd_o);
      chk("R10", "pins across update", {28'd0, pin_o[2], pin_o[3], 2'b00} >> 0,
          {28'd0, v[2], v[3], 2'b00});
    end

    // Random traffic against the model (R6 set/clear races, R4 modes, R9)
    for (int i = 0; i < 4000; i++) begin
      int sel;
      @(negedge clk);
      sel = $urandom_range(0, 9);
      rd_addr = 4'($urandom_range(0, 11));
      wr_en = (sel < 6);
      case ($urandom_range(0, 7))
        0: begin wr_addr = 4'd1; wr_data = $urandom_range(0, 2); end
        1: begin wr_addr = 4'd2; wr_data = $urandom_range(3, 15); end
        2: begin wr_addr = 4'd3; wr_data = $urandom; end
        3: begin wr_addr = 4'd5; wr_data = $urandom_range(0, 15); end
        4: begin wr_addr = 4'd0; wr_data = ($urandom_range(0, 9) != 0); end
        default: begin wr_addr = 4'($urandom_range(8, 11)); wr_data = $urandom_range(0, 15); end
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule